// File: doc/BRIEF.md
# Hit-Selective Channel Readout Serializer

This block drains the per-channel conversion results of a 16-channel front end onto one serial wire. On a start pulse it takes a snapshot of the channel hit mask. It then walks through the hit channels from channel 0 upward and sends one fixed-length record for each of them. Channels whose hit bit is clear are skipped and use no line time, so the length of a readout grows with the number of hits. Each record carries the channel index, the coarse timestamp with its extension bit, the gain-range flag, the charge code, and the fine-time flag and code. The coarse timestamp arrives in Gray code from a free-running counter and is sent as plain binary.

The block is used after conversion has finished. The result registers must stay stable from start until done. The serial data line, its valid qualifier and a one-cycle done pulse are all registered. Records follow one another with no idle cycle between them. With the default sizes, a full 16-hit readout takes 816 serial clocks, which is about 20 µs at a 40 MHz readout clock.

Top module: `hit_record_serializer`

## Requirements
- R1: While and after reset, with no start, `ser_valid`, `ser_done` and `ser_data` are all low.
- R2: A start pulse in idle with an all-zero hit mask sends no record bits: `ser_done` is high for exactly the cycle after the start edge and `ser_valid` stays low.
- R3: Only channels whose hit bit was set at the start edge are sent, one record each, in ascending channel order.
- R4: Each record is 51 bits, laid out from MSB to LSB as: channel index [50:47], coarse time [46:23], coarse extension [22], gain flag [21], charge [20:11], fine-time flag [10], fine time [9:0].
- R5: Records are sent MSB first, one bit per clock. The first bit appears in the cycle after the start edge.
- R6: The coarse-time field holds the binary equivalent of the channel's 24-bit Gray input: bit i is the XOR of Gray bits i and above.
- R7: `ser_valid` is high for every record bit and only then. Consecutive records are back to back, so a readout of N hits keeps `ser_valid` high for 51·N consecutive cycles.
- R8: `ser_done` is a one-cycle pulse in the cycle after the last record bit. `ser_valid` is low in that cycle.
- R9: A start pulse or a hit-mask change while a readout is running has no effect on the current readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a readout (ignored while busy) |
| hit_mask | input | 16 | Per-channel hit flags, sampled at start |
| coarse_gray | input | 384 | Per-channel 24-bit Gray coarse time, channel c at [24c+23:24c] |
| coarse_ext | input | 16 | Per-channel coarse extension bit |
| gain_sel | input | 16 | Per-channel gain-range flag |
| charge_code | input | 160 | Per-channel 10-bit charge, channel c at [10c+9:10c] |
| fine_valid | input | 16 | Per-channel fine-time flag |
| fine_code | input | 160 | Per-channel 10-bit fine time, channel c at [10c+9:10c] |
| ser_data | output | 1 | Serial record data |
| ser_valid | output | 1 | High while `ser_data` carries a record bit |
| ser_done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The embedded properties check the following on every cycle:
- `ser_done` lasts one cycle and never overlaps `ser_valid`.
- `ser_valid` only ever falls together with done.
- While sending, the pending-channel set only loses bits, one at a time.
- The channel finder always picks the lowest requesting channel.
- An empty start produces done on the next cycle.

The bench's scenarios are needed for the rest. They show that the bit stream has the right field layout, the right Gray-to-binary conversion, the ascending channel order and the correct total length for the sparse, single-edge-channel and fully-hit masks. They also show that a start pulse and a mask change in the middle of a readout leave the stream unchanged.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SEND = 1'b1} hrs_state_t;
endpackage

// File: rtl/hrs_lowest_finder.sv
module hrs_lowest_finder #(
  parameter int N   = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IDX_W'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end

  assign any = |req;

  // R3: the chosen channel has no lower requester and is a requester itself
  a_r3_lowest_pick: assert property (@(posedge clk) disable iff (rst)
    any |-> (((onehot - 1'b1) & req) == '0) && ((onehot & req) == onehot));
  a_r3_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    any |-> $onehot(onehot));
endmodule

// File: rtl/hrs_gray_to_bin.sv
module hrs_gray_to_bin #(
  parameter int W = 24
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign bin[i] = ^(gray >> i);
    end
  endgenerate
endmodule

// File: rtl/hit_record_serializer.sv
module hit_record_serializer
  import hrs_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int COARSE_W = 24,
  parameter int CHARGE_W = 10,
  parameter int FINE_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NUM_CH-1:0]            hit_mask,
  input  logic [NUM_CH*COARSE_W-1:0]   coarse_gray,
  input  logic [NUM_CH-1:0]            coarse_ext,
  input  logic [NUM_CH-1:0]            gain_sel,
  input  logic [NUM_CH*CHARGE_W-1:0]   charge_code,
  input  logic [NUM_CH-1:0]            fine_valid,
  input  logic [NUM_CH*FINE_W-1:0]     fine_code,
  output logic                         ser_data,
  output logic                         ser_valid,
  output logic                         ser_done
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int REC_W = CH_W + COARSE_W + 1 + 1 + CHARGE_W + 1 + FINE_W;
  localparam int CNT_W = $clog2(REC_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REC_W - 1);

  hrs_state_t        state;
  logic [NUM_CH-1:0] pend;
  logic [REC_W-1:0]  shreg;
  logic [CNT_W-1:0]  bitcnt;

  // per-channel field views
  logic [COARSE_W-1:0] gray_a   [NUM_CH];
  logic [CHARGE_W-1:0] charge_a [NUM_CH];
  logic [FINE_W-1:0]   fine_a   [NUM_CH];

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_unpack
      assign gray_a[c]   = coarse_gray[c*COARSE_W +: COARSE_W];
      assign charge_a[c] = charge_code[c*CHARGE_W +: CHARGE_W];
      assign fine_a[c]   = fine_code[c*FINE_W +: FINE_W];
    end
  endgenerate

  logic [NUM_CH-1:0]   scan_mask;
  logic                found;
  logic [CH_W-1:0]     sel_idx;
  logic [NUM_CH-1:0]   sel_oh;
  logic [COARSE_W-1:0] sel_bin;
  logic [REC_W-1:0]    record;

  assign scan_mask = (state == ST_IDLE) ? hit_mask : pend;

  hrs_lowest_finder #(.N(NUM_CH), .IDX_W(CH_W)) u_find (
    .clk(clk), .rst(rst), .req(scan_mask),
    .any(found), .idx(sel_idx), .onehot(sel_oh)
  );

  hrs_gray_to_bin #(.W(COARSE_W)) u_g2b (
    .gray(gray_a[sel_idx]), .bin(sel_bin)
  );

  assign record = {sel_idx, sel_bin, coarse_ext[sel_idx], gain_sel[sel_idx],
                   charge_a[sel_idx], fine_valid[sel_idx], fine_a[sel_idx]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      shreg     <= '0;
      bitcnt    <= '0;
      ser_valid <= 1'b0;
      ser_done  <= 1'b0;
    end else begin
      ser_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (found) begin
              shreg     <= record;
              pend      <= hit_mask & ~sel_oh;
              bitcnt    <= '0;
              state     <= ST_SEND;
              ser_valid <= 1'b1;
            end else begin
              ser_done <= 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            if (found) begin
              shreg <= record;
              pend  <= pend & ~sel_oh;
            end else begin
              shreg     <= '0;
              state     <= ST_IDLE;
              ser_valid <= 1'b0;
              ser_done  <= 1'b1;
            end
          end else begin
            shreg  <= shreg << 1;
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_data = shreg[REC_W-1];

  // R8: done is a single-cycle pulse and never overlaps valid data
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    ser_done |=> !ser_done);
  a_r8_done_no_valid: assert property (@(posedge clk) disable iff (rst)
    ser_done |-> !ser_valid);
  // R7: valid only ends at readout end, never in a gap
  a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid) |-> ser_done);
  // R2: empty mask yields done on the next cycle with no data
  a_r2_empty_done: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && hit_mask == '0) |=> (ser_done && !ser_valid));
  // R9: while sending, pending channels never grow and drop at most one per step
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && $past(state) == ST_SEND) |->
      ((pend & ~$past(pend)) == '0) && $onehot0($past(pend) & ~pend));
endmodule

// File: tb/sim_hit_record_serializer.sv
module sim_hit_record_serializer;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCH-1:0]    hit_mask = '0;
  logic [NCH*24-1:0] coarse_gray;
  logic [NCH-1:0]    coarse_ext, gain_sel, fine_valid;
  logic [NCH*10-1:0] charge_code, fine_code;
  logic ser_data, ser_valid, ser_done;

  logic [23:0] gray_v [NCH];
  logic [9:0]  chg_v  [NCH];
  logic [9:0]  fine_v [NCH];

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      coarse_gray[c*24 +: 24] = gray_v[c];
      charge_code[c*10 +: 10] = chg_v[c];
      fine_code[c*10 +: 10]   = fine_v[c];
    end
  end

  hit_record_serializer u0 (
    .clk(clk), .rst(rst), .start(start), .hit_mask(hit_mask),
    .coarse_gray(coarse_gray), .coarse_ext(coarse_ext), .gain_sel(gain_sel),
    .charge_code(charge_code), .fine_valid(fine_valid), .fine_code(fine_code),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_done(ser_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [50:0] exp_rec(input int c);
    logic [23:0] b;
    for (int i = 0; i < 24; i++) b[i] = ^(gray_v[c] >> i);
    return {4'(c), b, coarse_ext[c], gain_sel[c], chg_v[c], fine_valid[c], fine_v[c]};
  endfunction

  task automatic fill(input int seed);
    for (int c = 0; c < NCH; c++) begin
      gray_v[c] = 24'((c + 1) * 24'h3A5C91 + seed * 24'h0F1357);
      chg_v[c]  = 10'((c * 77 + seed * 13) ^ 10'h2AA);
      fine_v[c] = 10'((c * 191 + seed) ^ 10'h155);
    end
    coarse_ext = 16'(16'hC3A5 ^ seed);
    gain_sel   = 16'(16'h5A0F + seed);
    fine_valid = 16'(16'h96E1 ^ (seed << 3));
  endtask

  // at a negedge on entry and on exit
  task automatic readout(input logic [NCH-1:0] mask, input bit poke);
    bit q[$];
    int idx;
    hit_mask = mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mask == '0) begin
      chk(ser_done === 1'b1 && ser_valid === 1'b0, "R2 done after empty start",
          {ser_done, ser_valid}, 2'b10);
      @(negedge clk);
      chk(ser_done === 1'b0 && ser_valid === 1'b0, "R2 done single pulse",
          {ser_done, ser_valid}, 2'b00);
      return;
    end
    for (int c = 0; c < NCH; c++)
      if (mask[c]) begin
        logic [50:0] r;
        r = exp_rec(c);
        for (int b = 50; b >= 0; b--) q.push_back(r[b]);
      end
    idx = 0;
    while (q.size() > 0) begin
      bit e;
      e = q.pop_front();
      chk(ser_valid === 1'b1, "R7 valid contiguous", ser_valid, 1);
      chk(ser_data === e, "R3 R4 R5 R6 record bit", ser_data, e);
      if (poke && idx == 10) begin
        start = 1'b1;     // R9: ignored start while busy
        hit_mask = ~mask; // R9: ignored mask change
      end
      if (poke && idx == 11) start = 1'b0;
      @(negedge clk);
      idx++;
    end
    chk(ser_done === 1'b1 && ser_valid === 1'b0, "R8 done after last bit",
        {ser_done, ser_valid}, 2'b10);
    hit_mask = mask;
    @(negedge clk);
    chk(ser_done === 1'b0 && ser_valid === 1'b0, "R8 done one cycle",
        {ser_done, ser_valid}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk(ser_valid === 1'b0 && ser_done === 1'b0 && ser_data === 1'b0, "R1 in reset",
        {ser_valid, ser_done, ser_data}, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ser_valid === 1'b0 && ser_done === 1'b0 && ser_data === 1'b0, "R1 idle",
          {ser_valid, ser_done, ser_data}, 0);
    end
    readout(16'h0000, 1'b0);      // R2
    readout(16'h0001, 1'b0);      // R3 lowest channel
    readout(16'h8000, 1'b0);      // R3 highest channel
    fill(5);
    readout(16'hA5C3, 1'b1);      // R3 sparse, R9 busy start
    readout(16'hFFFF, 1'b0);      // R7 full readout back to back
    fill(9);
    readout(16'h8001, 1'b1);      // R9
    readout(16'h0000, 1'b0);      // R2 again after traffic
    @(negedge clk);
    chk(ser_valid === 1'b0 && ser_done === 1'b0, "R1 idle at end",
        {ser_valid, ser_done}, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule